// File: doc/BRIEF.md
# Predicated Instruction Commit Gate

This block sits at the writeback stage of a simple in-order pipeline. Each instruction that reaches writeback names a predicate register. The gate looks that register up in a small predicate file. When the value is true the gate lets the instruction write its destination register and perform its memory access. When the value is false the instruction is turned into a no-op and a squash indication is raised. A per-register ready bit tracks predicates whose producer has issued but not yet written back.

A parameter selects how an unresolved predicate is handled. In stall mode the gate holds the pipeline in order until the predicate arrives. In late-resolve mode the instruction leaves writeback without its predicate and waits in a single pending slot. The gate commits or squashes it when the predicate is produced. A newer instruction stalls only while that slot is occupied.

Top module: `pred_commit_gate`

## Requirements
- R1: After reset every predicate register is ready, and registers 1 and above hold false. An instruction naming such a register is squashed at once, with no stall.
- R2: Predicate register 0 always reads as true and ready. Writes and producer issues aimed at it have no effect, so an instruction naming it always commits.
- R3: A valid instruction whose predicate is ready and non-zero raises `rf_we` in the same cycle, with `rf_waddr`/`rf_wdata` equal to its destination and data. Any non-zero value, including one with only upper bits set, counts as true.
- R4: A valid instruction whose predicate is ready and zero raises `squash` for that cycle, with `rf_we` and `mem_en` both low.
- R5: In stall mode, a valid instruction whose predicate is not ready holds `stall` high, with no write, no memory access and no squash, until the predicate is produced.
- R6: A predicate write (`pset_valid`) in the same cycle as a dependent read resolves that read with the newly written value in that same cycle.
- R7: A producer issue (`piss_valid`) clears the ready bit of its register from the next cycle. If an issue and a write hit the same register in one cycle, the register ends up not ready.
- R8: In late-resolve mode, an instruction with an unready predicate does not stall and produces no effect. In the cycle its predicate is written, it commits with its captured destination and data, or it raises a one-cycle `squash`.
- R9: In late-resolve mode, while an instruction waits in the pending slot, any new valid instruction sees `stall` high. It completes in order after the pending one.
- R10: `mem_en` is high exactly when an instruction commits with its memory-access flag set. A squashed instruction never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | Instruction present at writeback |
| wb_pidx | input | $clog2(NPRED) | Predicate register named by the instruction |
| wb_rd | input | $clog2(NREG) | Destination register index |
| wb_data | input | DW | Result data |
| wb_mem | input | 1 | Instruction performs a memory access |
| piss_valid | input | 1 | A predicate producer issues |
| piss_idx | input | $clog2(NPRED) | Register that producer will write |
| pset_valid | input | 1 | A predicate producer writes back |
| pset_idx | input | $clog2(NPRED) | Register being written |
| pset_val | input | DW | Value written (non-zero means true) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | $clog2(NREG) | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| mem_en | output | 1 | Memory access allowed |
| stall | output | 1 | Hold the instruction at writeback |
| squash | output | 1 | Instruction was turned into a no-op |

## Verification
A ready bit stuck high lets an instruction commit on the old, stale predicate value. That shows at once as a write or squash in the very cycle where `stall` was due. A ready bit stuck low shows as a stall that never ends. A wrong stored value swaps `rf_we` and `squash` on the first instruction that reads the register. In late-resolve mode, a pending slot that fails to capture or to clear shows within one cycle: either a missing commit or squash when the predicate arrives, or a `stall` that stays high after the slot has drained.

// File: rtl/pcg_pkg.sv
// Shared types for the predicated commit gate.
// Assumes: nothing beyond IEEE 1800-2017.
package pcg_pkg;
    // How an instruction with an unresolved predicate is handled
    typedef enum logic {
        PCG_STALL = 1'b0,
        PCG_LATE  = 1'b1
    } pcg_mode_e;
endpackage

// File: rtl/pcg_pred_file.sv
// Predicate register file with one ready bit per register and two
// bypassed read ports. Register 0 is constant true and always ready.
// Assumes: NPRED is a power of two; an issue and a write to the same
// register in one cycle leave it not ready (the issue is younger).
module pcg_pred_file #(
    parameter int NPRED = 8,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [$clog2(NPRED)-1:0] iss_idx,
    input  logic                     set_valid,
    input  logic [$clog2(NPRED)-1:0] set_idx,
    input  logic [DW-1:0]            set_val,
    input  logic [$clog2(NPRED)-1:0] ra_idx,
    output logic                     ra_ready,
    output logic                     ra_true,
    input  logic [$clog2(NPRED)-1:0] rb_idx,
    output logic                     rb_ready,
    output logic                     rb_true
);
    localparam int PW = $clog2(NPRED);

    logic [NPRED-1:0] rdy_q;
    logic [NPRED-1:0] val_q;
    logic             set_nz;

    assign set_nz = |set_val;

    genvar gi;
    generate
        for (gi = 0; gi < NPRED; gi++) begin : g_reg
            if (gi == 0) begin : g_zero
                assign rdy_q[gi] = 1'b1;
                assign val_q[gi] = 1'b1;
            end else begin : g_live
                // Update value and ready bit; a same-cycle issue clears last
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        rdy_q[gi] <= 1'b1;
                        val_q[gi] <= 1'b0;
                    end else begin
                        if (set_valid && set_idx == PW'(gi)) begin
                            rdy_q[gi] <= 1'b1;
                            val_q[gi] <= set_nz;
                        end
                        if (iss_valid && iss_idx == PW'(gi))
                            rdy_q[gi] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    // Read port A with write bypass
    always_comb begin
        ra_ready = rdy_q[ra_idx];
        ra_true  = val_q[ra_idx];
        if (set_valid && set_idx == ra_idx && ra_idx != '0) begin
            ra_ready = 1'b1;
            ra_true  = set_nz;
        end
    end

    // Read port B with write bypass
    always_comb begin
        rb_ready = rdy_q[rb_idx];
        rb_true  = val_q[rb_idx];
        if (set_valid && set_idx == rb_idx && rb_idx != '0) begin
            rb_ready = 1'b1;
            rb_true  = set_nz;
        end
    end

    // R7
    property issue_clears_p;
        @(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_idx != '0) |=> !rdy_q[$past(iss_idx)];
    endproperty
    issue_clears_chk: assert property (issue_clears_p);

    // R2
    property zero_true_p;
        @(posedge clk) disable iff (!rst_n)
            (ra_idx == '0) |-> (ra_ready && ra_true);
    endproperty
    zero_true_chk: assert property (zero_true_p);
endmodule

// File: rtl/pcg_commit_ctl.sv
// Decides commit, squash or stall for the instruction at writeback.
// In late-resolve mode it keeps one pending instruction whose predicate
// is looked up on read port B each cycle.
// Assumes: upstream holds a stalled instruction unchanged.
module pcg_commit_ctl
    import pcg_pkg::*;
#(
    parameter int        NPRED = 8,
    parameter int        NREG  = 32,
    parameter int        DW    = 32,
    parameter pcg_mode_e MODE  = PCG_STALL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wb_valid,
    input  logic [$clog2(NPRED)-1:0] wb_pidx,
    input  logic [$clog2(NREG)-1:0]  wb_rd,
    input  logic [DW-1:0]            wb_data,
    input  logic                     wb_mem,
    input  logic                     a_ready,
    input  logic                     a_true,
    output logic [$clog2(NPRED)-1:0] b_idx,
    input  logic                     b_ready,
    input  logic                     b_true,
    output logic                     rf_we,
    output logic [$clog2(NREG)-1:0]  rf_waddr,
    output logic [DW-1:0]            rf_wdata,
    output logic                     mem_en,
    output logic                     stall,
    output logic                     squash,
    output logic                     pend_busy
);
    localparam int PW = $clog2(NPRED);
    localparam int RW = $clog2(NREG);

    generate
        if (MODE == PCG_LATE) begin : g_late
            logic          pend_v;
            logic [PW-1:0] pend_pidx;
            logic [RW-1:0] pend_rd;
            logic [DW-1:0] pend_data;
            logic          pend_mem;

            // Capture an unresolved instruction; release when resolved
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_v    <= 1'b0;
                    pend_pidx <= '0;
                    pend_rd   <= '0;
                    pend_data <= '0;
                    pend_mem  <= 1'b0;
                end else if (pend_v) begin
                    if (b_ready) pend_v <= 1'b0;
                end else if (wb_valid && !a_ready) begin
                    pend_v    <= 1'b1;
                    pend_pidx <= wb_pidx;
                    pend_rd   <= wb_rd;
                    pend_data <= wb_data;
                    pend_mem  <= wb_mem;
                end
            end

            assign b_idx     = pend_pidx;
            assign pend_busy = pend_v;

            // Resolve the pending slot first, else the incoming instruction
            always_comb begin
                rf_we    = 1'b0;
                rf_waddr = wb_rd;
                rf_wdata = wb_data;
                mem_en   = 1'b0;
                stall    = 1'b0;
                squash   = 1'b0;
                if (pend_v) begin
                    stall    = wb_valid;
                    rf_waddr = pend_rd;
                    rf_wdata = pend_data;
                    if (b_ready) begin
                        rf_we  = b_true;
                        mem_en = b_true && pend_mem;
                        squash = !b_true;
                    end
                end else if (wb_valid && a_ready) begin
                    rf_we  = a_true;
                    mem_en = a_true && wb_mem;
                    squash = !a_true;
                end
            end
        end else begin : g_stall
            assign b_idx     = '0;
            assign pend_busy = 1'b0;

            // Commit, squash, or hold in order until the predicate is ready
            always_comb begin
                rf_we    = 1'b0;
                rf_waddr = wb_rd;
                rf_wdata = wb_data;
                mem_en   = 1'b0;
                stall    = 1'b0;
                squash   = 1'b0;
                if (wb_valid) begin
                    if (!a_ready) begin
                        stall = 1'b1;
                    end else begin
                        rf_we  = a_true;
                        mem_en = a_true && wb_mem;
                        squash = !a_true;
                    end
                end
            end
        end
    endgenerate

    // R4
    property squash_quiet_p;
        @(posedge clk) disable iff (!rst_n)
            squash |-> (!rf_we && !mem_en);
    endproperty
    squash_quiet_chk: assert property (squash_quiet_p);

    // R10
    property mem_needs_we_p;
        @(posedge clk) disable iff (!rst_n)
            mem_en |-> rf_we;
    endproperty
    mem_needs_we_chk: assert property (mem_needs_we_p);
endmodule

// File: rtl/pred_commit_gate.sv
// Writeback-stage predicate gate: joins the predicate file and the
// commit controller. MODE picks stall or late-resolve handling.
// Assumes: one instruction per cycle at writeback, held while stalled.
module pred_commit_gate
    import pcg_pkg::*;
#(
    parameter int        NPRED = 8,
    parameter int        NREG  = 32,
    parameter int        DW    = 32,
    parameter pcg_mode_e MODE  = PCG_STALL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wb_valid,
    input  logic [$clog2(NPRED)-1:0] wb_pidx,
    input  logic [$clog2(NREG)-1:0]  wb_rd,
    input  logic [DW-1:0]            wb_data,
    input  logic                     wb_mem,
    input  logic                     piss_valid,
    input  logic [$clog2(NPRED)-1:0] piss_idx,
    input  logic                     pset_valid,
    input  logic [$clog2(NPRED)-1:0] pset_idx,
    input  logic [DW-1:0]            pset_val,
    output logic                     rf_we,
    output logic [$clog2(NREG)-1:0]  rf_waddr,
    output logic [DW-1:0]            rf_wdata,
    output logic                     mem_en,
    output logic                     stall,
    output logic                     squash
);
    localparam int PW = $clog2(NPRED);

    logic          a_ready, a_true, b_ready, b_true, pend_busy;
    logic [PW-1:0] b_idx;

    pcg_pred_file #(.NPRED(NPRED), .DW(DW)) pfile_i (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(piss_valid), .iss_idx(piss_idx),
        .set_valid(pset_valid), .set_idx(pset_idx), .set_val(pset_val),
        .ra_idx(wb_pidx), .ra_ready(a_ready), .ra_true(a_true),
        .rb_idx(b_idx), .rb_ready(b_ready), .rb_true(b_true)
    );

    pcg_commit_ctl #(.NPRED(NPRED), .NREG(NREG), .DW(DW), .MODE(MODE)) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .wb_valid(wb_valid), .wb_pidx(wb_pidx), .wb_rd(wb_rd),
        .wb_data(wb_data), .wb_mem(wb_mem),
        .a_ready(a_ready), .a_true(a_true),
        .b_idx(b_idx), .b_ready(b_ready), .b_true(b_true),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_en(mem_en), .stall(stall), .squash(squash),
        .pend_busy(pend_busy)
    );

    // R5
    property stall_no_effect_p;
        @(posedge clk) disable iff (!rst_n)
            (MODE == PCG_STALL && stall) |-> (!rf_we && !squash && !mem_en);
    endproperty
    stall_no_effect_chk: assert property (stall_no_effect_p);

    // R9
    property pending_blocks_p;
        @(posedge clk) disable iff (!rst_n)
            (pend_busy && wb_valid) |-> stall;
    endproperty
    pending_blocks_chk: assert property (pending_blocks_p);

    // R8
    property late_never_stalls_empty_p;
        @(posedge clk) disable iff (!rst_n)
            (MODE == PCG_LATE && !pend_busy) |-> !stall;
    endproperty
    late_never_stalls_empty_chk: assert property (late_never_stalls_empty_p);
endmodule

// File: tb/pred_commit_gate_tb_top.sv
// Scoreboard bench: beats push expected commit/squash items into a queue
// per instance; a negedge monitor pops and compares every event.
module pred_commit_gate_tb_top;
    import pcg_pkg::*;

    localparam int NPRED = 8;
    localparam int NREG  = 32;
    localparam int DW    = 32;
    localparam int PW    = $clog2(NPRED);
    localparam int RW    = $clog2(NREG);

    typedef struct {
        bit          commit;
        logic [RW-1:0] rd;
        logic [DW-1:0] data;
        bit          mem;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          wb_valid [2];
    logic [PW-1:0] wb_pidx  [2];
    logic [RW-1:0] wb_rd    [2];
    logic [DW-1:0] wb_data  [2];
    logic          wb_mem   [2];
    logic          piss_valid [2];
    logic [PW-1:0] piss_idx [2];
    logic          pset_valid [2];
    logic [PW-1:0] pset_idx [2];
    logic [DW-1:0] pset_val [2];
    logic          rf_we    [2];
    logic [RW-1:0] rf_waddr [2];
    logic [DW-1:0] rf_wdata [2];
    logic          mem_en   [2];
    logic          stall    [2];
    logic          squash   [2];

    exp_t q [2][$];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    pred_commit_gate #(.NPRED(NPRED), .NREG(NREG), .DW(DW), .MODE(PCG_STALL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_valid(wb_valid[0]), .wb_pidx(wb_pidx[0]), .wb_rd(wb_rd[0]),
        .wb_data(wb_data[0]), .wb_mem(wb_mem[0]),
        .piss_valid(piss_valid[0]), .piss_idx(piss_idx[0]),
        .pset_valid(pset_valid[0]), .pset_idx(pset_idx[0]), .pset_val(pset_val[0]),
        .rf_we(rf_we[0]), .rf_waddr(rf_waddr[0]), .rf_wdata(rf_wdata[0]),
        .mem_en(mem_en[0]), .stall(stall[0]), .squash(squash[0])
    );

    pred_commit_gate #(.NPRED(NPRED), .NREG(NREG), .DW(DW), .MODE(PCG_LATE)) dut_late_i (
        .clk(clk), .rst_n(rst_n),
        .wb_valid(wb_valid[1]), .wb_pidx(wb_pidx[1]), .wb_rd(wb_rd[1]),
        .wb_data(wb_data[1]), .wb_mem(wb_mem[1]),
        .piss_valid(piss_valid[1]), .piss_idx(piss_idx[1]),
        .pset_valid(pset_valid[1]), .pset_idx(pset_idx[1]), .pset_val(pset_val[1]),
        .rf_we(rf_we[1]), .rf_waddr(rf_waddr[1]), .rf_wdata(rf_wdata[1]),
        .mem_en(mem_en[1]), .stall(stall[1]), .squash(squash[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int m = 0; m < 2; m++) begin
            wb_valid[m] = 1'b0; wb_pidx[m] = '0; wb_rd[m] = '0;
            wb_data[m] = '0; wb_mem[m] = 1'b0;
            piss_valid[m] = 1'b0; piss_idx[m] = '0;
            pset_valid[m] = 1'b0; pset_idx[m] = '0; pset_val[m] = '0;
        end
    endtask

    // Start a beat: inputs change shortly after the rising edge
    task automatic beat();
        @(posedge clk);
        #1;
        idle_all();
    endtask

    task automatic put_wb(input int m, input int p, input int rd,
                          input logic [DW-1:0] d, input bit mm);
        wb_valid[m] = 1'b1; wb_pidx[m] = PW'(p); wb_rd[m] = RW'(rd);
        wb_data[m] = d; wb_mem[m] = mm;
    endtask

    task automatic put_set(input int m, input int p, input logic [DW-1:0] v);
        pset_valid[m] = 1'b1; pset_idx[m] = PW'(p); pset_val[m] = v;
    endtask

    task automatic put_iss(input int m, input int p);
        piss_valid[m] = 1'b1; piss_idx[m] = PW'(p);
    endtask

    task automatic expect_ev(input int m, input bit c, input int rd,
                             input logic [DW-1:0] d, input bit mm, input string tag);
        exp_t e;
        e.commit = c; e.rd = RW'(rd); e.data = d; e.mem = mm; e.tag = tag;
        q[m].push_back(e);
    endtask

    task automatic chk_stall(input int m, input bit exp, input string tag);
        @(negedge clk);
        chk(stall[m] == exp, tag, "stall", DW'(stall[m]), DW'(exp));
    endtask

    // Monitor: every commit or squash must match the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                if (rf_we[m] || squash[m]) begin
                    if (q[m].size() == 0) begin
                        chk(1'b0, "R4/R5", $sformatf("unexpected event dut%0d", m),
                            DW'({rf_we[m], squash[m]}), 0);
                    end else begin
                        exp_t e;
                        e = q[m].pop_front();
                        chk(rf_we[m] == e.commit && squash[m] == !e.commit,
                            e.tag, "we/squash", DW'({rf_we[m], squash[m]}),
                            DW'({e.commit, !e.commit}));
                        chk(mem_en[m] == (e.commit && e.mem), e.tag, "mem_en",
                            DW'(mem_en[m]), DW'(e.commit && e.mem));
                        if (e.commit) begin
                            chk(rf_waddr[m] == e.rd, e.tag, "waddr",
                                DW'(rf_waddr[m]), DW'(e.rd));
                            chk(rf_wdata[m] == e.data, e.tag, "wdata",
                                rf_wdata[m], e.data);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset-false predicate squashes at once, memory flag ignored
        beat(); put_wb(0, 3, 5, 32'h11, 1'b1); expect_ev(0, 1'b0, 5, 0, 1'b1, "R1");
        chk_stall(0, 1'b0, "R1");
        // R2: register 0 commits
        beat(); put_wb(0, 0, 7, 32'hAAAA, 1'b1); expect_ev(0, 1'b1, 7, 32'hAAAA, 1'b1, "R2");
        // R2: write of zero to register 0 and an issue to it are ignored
        beat(); put_set(0, 0, 0); put_iss(0, 0);
        beat(); put_wb(0, 0, 8, 32'h88, 1'b0); expect_ev(0, 1'b1, 8, 32'h88, 1'b0, "R2");
        chk_stall(0, 1'b0, "R2");
        // R3: upper-bit-only value is true; R10 memory flag passes
        beat(); put_set(0, 2, 32'h0000_0100);
        beat(); put_wb(0, 2, 12, 32'h1234, 1'b1); expect_ev(0, 1'b1, 12, 32'h1234, 1'b1, "R3");
        // R5/R7: producer issued, consumer stalls
        beat(); put_iss(0, 4);
        beat(); put_wb(0, 4, 13, 32'h4444, 1'b1); chk_stall(0, 1'b1, "R5");
        beat(); put_wb(0, 4, 13, 32'h4444, 1'b1); chk_stall(0, 1'b1, "R7");
        // R6: same-cycle write resolves the stalled read
        beat(); put_wb(0, 4, 13, 32'h4444, 1'b1); put_set(0, 4, 32'd5);
        expect_ev(0, 1'b1, 13, 32'h4444, 1'b1, "R6");
        chk_stall(0, 1'b0, "R6");
        // R7: issue and write in one cycle leave the register unready
        beat(); put_iss(0, 5); put_set(0, 5, 32'd1);
        beat(); put_wb(0, 5, 14, 32'h5555, 1'b1); chk_stall(0, 1'b1, "R7");
        // R4: zero written while stalled squashes, no memory access
        beat(); put_wb(0, 5, 14, 32'h5555, 1'b1); put_set(0, 5, 32'd0);
        expect_ev(0, 1'b0, 14, 0, 1'b1, "R4");
        chk_stall(0, 1'b0, "R4");

        // R8: late mode captures without stalling
        beat(); put_iss(1, 3);
        beat(); put_wb(1, 3, 9, 32'h33, 1'b1); chk_stall(1, 1'b0, "R8");
        beat(); chk_stall(1, 1'b0, "R8");
        // R9: newer instruction stalls behind the pending one
        beat(); put_wb(1, 0, 10, 32'hA0, 1'b0); chk_stall(1, 1'b1, "R9");
        beat(); put_wb(1, 0, 10, 32'hA0, 1'b0); put_set(1, 3, 32'd1);
        expect_ev(1, 1'b1, 9, 32'h33, 1'b1, "R8");
        chk_stall(1, 1'b1, "R9");
        beat(); put_wb(1, 0, 10, 32'hA0, 1'b0);
        expect_ev(1, 1'b1, 10, 32'hA0, 1'b0, "R9");
        chk_stall(1, 1'b0, "R9");
        // R8: pending instruction squashed for one cycle only
        beat(); put_iss(1, 6);
        beat(); put_wb(1, 6, 11, 32'h66, 1'b1); chk_stall(1, 1'b0, "R8");
        beat(); put_set(1, 6, 32'd0); expect_ev(1, 1'b0, 11, 0, 1'b1, "R8");
        beat(); @(negedge clk);
        chk(squash[1] == 1'b0, "R8", "squash pulse length", DW'(squash[1]), 0);
        // R3: ready-true predicate commits immediately in late mode
        beat(); put_wb(1, 3, 15, 32'hF0F0, 1'b1); expect_ev(1, 1'b1, 15, 32'hF0F0, 1'b1, "R3");
        chk_stall(1, 1'b0, "R3");

        beat(); beat();
        @(negedge clk);
        chk(q[0].size() == 0, "R3", "missing events dut0", DW'(q[0].size()), 0);
        chk(q[1].size() == 0, "R8", "missing events dut1", DW'(q[1].size()), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule